// File: doc/BRIEF.md
# Double-to-Integer Saturating Converter

The block turns a 64-bit IEEE 754 binary64 operand into an integer that is `INT_W` bits wide. `INT_W` is 32 or 64. A two-bit field selects the rounding direction. A two-bit policy field selects one of three target behaviours: a signed integer that clamps at its limits, an unsigned integer that clamps at its limits, or a two's-complement result that keeps only the low-order bits of the exact rounded value. The outputs are the integer and two flags. `invalid` marks results that are out of range or not a number. `inexact` marks in-range results that lost a fraction.

The conversion logic is combinational. It unpacks the operand, shifts it into a fixed-point magnitude, rounds that magnitude, and then applies the range check and clamp. One output register holds the result, so a result appears one clock after its operands are presented. The range check looks at the magnitude after rounding. A value that rounds up across an integer limit is therefore caught as an overflow, and is not reported as a wrapped or sign-flipped number.

Top module: `f2i_conv`

## Requirements
- R1: While rst_ni is low, result_o, invalid_o and inexact_o are all zero.
- R2: In-range operands give the rounded integer on the clock after they are sampled. rnd_i encodings: 00 nearest with ties to even, 01 toward zero, 10 toward +infinity, 11 toward -infinity.
- R3: With policy_i = 00 (signed clamp), a rounded value above 2^(INT_W-1)-1 gives 0x7F..F, and one below -2^(INT_W-1) gives 0x80..0. Both set invalid_o. A positive overflow never yields the negative limit.
- R4: With policy_i = 01 (unsigned clamp), a rounded value above 2^INT_W-1 gives all ones with invalid_o. A negative operand whose rounded value is nonzero gives 0 with invalid_o. A negative operand that rounds to zero gives 0 without invalid_o.
- R5: With policy_i = 10 or 11 (wrap), the result is the low INT_W bits of the two's-complement rounded value, including for finite magnitudes of 2^65 and above. invalid_o is set when that value lies outside the signed INT_W range.
- R6: Overflow is judged after rounding. An operand that rounds to exactly one above the largest value of the target is clamped and flags invalid_o.
- R7: inexact_o is set when the result is in range and nonzero fraction bits were dropped. It is never set together with invalid_o.
- R8: A NaN of either sign gives all ones under the unsigned policy and 0x7F..F under the signed and wrap policies, with invalid_o. Infinities clamp by sign: signed clamping is used under the wrap policy, and unsigned clamping gives all ones for +infinity and 0 for -infinity.
- R9: Zeros and subnormal operands give 0, except that a directed rounding away from zero gives +1 or -1. Nonzero subnormals set inexact_o unless the result is invalid.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| operand_i | input | 64 | binary64 operand |
| rnd_i | input | 2 | Rounding direction |
| policy_i | input | 2 | 00 signed clamp, 01 unsigned clamp, 1x wrap |
| result_o | output | INT_W | Converted integer, registered |
| invalid_o | output | 1 | Out of range or NaN, registered |
| inexact_o | output | 1 | In-range result lost fraction bits, registered |

## Verification
The bench builds the block with INT_W = 32. In that configuration every integer limit, and every point a quarter away from one, is an exact double. A sweep of quarter-step values around 0, 2^31, 2^32 and 2^36, of both signs, can then be rounded exactly in the bench under all four directions and all policies. Directed operands cover the remaining paths: NaNs, infinities, subnormals, signed zero and magnitudes of 2^65 and above.

// File: rtl/f2i_pkg.sv
package f2i_pkg;
  localparam int EXP_W   = 11;
  localparam int FRAC_W  = 52;
  localparam int BIAS    = 1023;
  localparam int MAG_W   = 66;                   // holds |x| < 2^65 plus a round carry
  localparam int INT_EXP = BIAS + FRAC_W;        // biased exponent where ulp == 1
  localparam int BIG_EXP = BIAS + MAG_W - 1;     // |x| >= 2^65

  typedef enum logic [1:0] {
    RND_NE = 2'b00, RND_TZ = 2'b01, RND_UP = 2'b10, RND_DN = 2'b11
  } rnd_e;

  typedef enum logic [1:0] {
    POL_SSAT = 2'b00, POL_USAT = 2'b01, POL_WRAP = 2'b10, POL_WRAP_ALT = 2'b11
  } pol_e;

  typedef struct packed {
    logic             sign;
    logic             nan;
    logic             inf;
    logic             big;
    logic [MAG_W-1:0] ip;
    logic             grd;
    logic             stk;
    logic [63:0]      wrap_big;
  } unp_t;
endpackage

// File: rtl/f2i_unpack.sv
module f2i_unpack
  import f2i_pkg::*;
(
  input  logic [63:0] op_i,
  output unp_t        unp_o
);
  logic [EXP_W-1:0]  ex, ex_eff, sh;
  logic [FRAC_W-1:0] fr;
  logic [FRAC_W:0]   mant;
  logic [FRAC_W+64:0] frame;
  unp_t u;

  always_comb begin
    ex     = op_i[62:52];
    fr     = op_i[51:0];
    mant   = {|ex, fr};
    ex_eff = (ex == '0) ? EXP_W'(1) : ex;
    u          = '0;
    u.sign     = op_i[63];
    u.nan      = (&ex) & (|fr);
    u.inf      = (&ex) & ~(|fr);
    u.big      = ex >= EXP_W'(BIG_EXP);
    frame      = '0;
    sh         = '0;
    if (ex >= EXP_W'(INT_EXP)) begin
      // integral value: left shift, no fraction
      sh         = ex - EXP_W'(INT_EXP);
      u.ip       = MAG_W'(mant) << sh;
      u.wrap_big = 64'(mant) << sh;
    end else begin
      sh = EXP_W'(INT_EXP) - ex_eff;
      if (sh > EXP_W'(64)) begin
        u.stk = |mant;
      end else begin
        frame = {mant, 64'b0} >> sh;
        u.ip  = MAG_W'(frame[FRAC_W+64:64]);
        u.grd = frame[63];
        u.stk = |frame[62:0];
      end
    end
    unp_o = u;
  end
endmodule

// File: rtl/f2i_round.sv
module f2i_round
  import f2i_pkg::*;
(
  input  logic [MAG_W-1:0] ip_i,
  input  logic             grd_i,
  input  logic             stk_i,
  input  logic             sign_i,
  input  rnd_e             rnd_i,
  output logic [MAG_W-1:0] mag_o,
  output logic             lost_o
);
  logic inc;

  always_comb begin
    unique case (rnd_i)
      RND_NE:  inc = grd_i & (stk_i | ip_i[0]);
      RND_TZ:  inc = 1'b0;
      RND_UP:  inc = (grd_i | stk_i) & ~sign_i;
      default: inc = (grd_i | stk_i) & sign_i;
    endcase
    mag_o  = ip_i + MAG_W'(inc);
    lost_o = grd_i | stk_i;
  end
endmodule

// File: rtl/f2i_pack.sv
module f2i_pack
  import f2i_pkg::*;
#(
  parameter int INT_W = 64
) (
  input  unp_t             unp_i,
  input  logic [MAG_W-1:0] mag_i,
  input  logic             lost_i,
  input  pol_e             pol_i,
  output logic [INT_W-1:0] res_o,
  output logic             inv_o,
  output logic             inx_o
);
  localparam logic [MAG_W-1:0] LIM_SPOS = (MAG_W'(1) << (INT_W - 1)) - MAG_W'(1);
  localparam logic [MAG_W-1:0] LIM_SNEG = MAG_W'(1) << (INT_W - 1);
  localparam logic [MAG_W-1:0] LIM_UMAX = (MAG_W'(1) << INT_W) - MAG_W'(1);
  localparam logic [INT_W-1:0] R_SMAX   = {1'b0, {(INT_W-1){1'b1}}};
  localparam logic [INT_W-1:0] R_SMIN   = {1'b1, {(INT_W-1){1'b0}}};
  localparam logic [INT_W-1:0] R_UMAX   = '1;

  logic             ovf_s, ovf_u;
  logic [MAG_W-1:0] sval;
  logic [INT_W-1:0] ssat, usat, wlow;

  always_comb begin
    ovf_s = unp_i.sign ? (mag_i > LIM_SNEG) : (mag_i > LIM_SPOS);
    ovf_u = unp_i.sign ? (mag_i != '0)      : (mag_i > LIM_UMAX);
    sval  = unp_i.sign ? (~mag_i + MAG_W'(1)) : mag_i;
    ssat  = unp_i.sign ? R_SMIN : R_SMAX;
    usat  = unp_i.sign ? '0 : R_UMAX;
    wlow  = unp_i.sign ? (~unp_i.wrap_big[INT_W-1:0] + INT_W'(1))
                       : unp_i.wrap_big[INT_W-1:0];
    inv_o = 1'b1;
    if (unp_i.nan) begin
      res_o = (pol_i == POL_USAT) ? R_UMAX : R_SMAX;
    end else if (unp_i.inf) begin
      res_o = (pol_i == POL_USAT) ? usat : ssat;
    end else if (unp_i.big) begin
      unique case (pol_i)
        POL_SSAT: res_o = ssat;
        POL_USAT: res_o = usat;
        default:  res_o = wlow;
      endcase
    end else begin
      unique case (pol_i)
        POL_SSAT: begin
          res_o = ovf_s ? ssat : sval[INT_W-1:0];
          inv_o = ovf_s;
        end
        POL_USAT: begin
          res_o = ovf_u ? usat : mag_i[INT_W-1:0];
          inv_o = ovf_u;
        end
        default: begin
          res_o = sval[INT_W-1:0];
          inv_o = ovf_s;
        end
      endcase
    end
    inx_o = lost_i & ~inv_o;
  end
endmodule

// File: rtl/f2i_conv.sv
module f2i_conv
  import f2i_pkg::*;
#(
  parameter int INT_W = 64
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [63:0]      operand_i,
  input  logic [1:0]       rnd_i,
  input  logic [1:0]       policy_i,
  output logic [INT_W-1:0] result_o,
  output logic             invalid_o,
  output logic             inexact_o
);
  localparam logic [INT_W-1:0] R_SMAX = {1'b0, {(INT_W-1){1'b1}}};

  unp_t             unp;
  logic [MAG_W-1:0] mag;
  logic             lost;
  pol_e             pol;
  logic [INT_W-1:0] nxt_res;
  logic             nxt_inv, nxt_inx;

  assign pol = pol_e'(policy_i);

  f2i_unpack u_unpack (.op_i(operand_i), .unp_o(unp));

  f2i_round u_round (
    .ip_i(unp.ip), .grd_i(unp.grd), .stk_i(unp.stk), .sign_i(unp.sign),
    .rnd_i(rnd_e'(rnd_i)), .mag_o(mag), .lost_o(lost)
  );

  f2i_pack #(.INT_W(INT_W)) u_pack (
    .unp_i(unp), .mag_i(mag), .lost_i(lost), .pol_i(pol),
    .res_o(nxt_res), .inv_o(nxt_inv), .inx_o(nxt_inx)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      result_o  <= '0;
      invalid_o <= 1'b0;
      inexact_o <= 1'b0;
    end else begin
      result_o  <= nxt_res;
      invalid_o <= nxt_inv;
      inexact_o <= nxt_inx;
    end
  end

  assert_ssat_pos_max_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pol == POL_SSAT && !unp.sign && !unp.nan && nxt_inv) |-> nxt_res == R_SMAX);

  assert_usat_neg_zero_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pol == POL_USAT && unp.sign && !unp.nan) |-> nxt_res == '0);

  assert_round_carry_ovf_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pol == POL_SSAT && !unp.sign && !unp.nan && !unp.inf && !unp.big &&
     mag == (MAG_W'(1) << (INT_W - 1))) |-> nxt_inv);

  assert_inexact_excl_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(invalid_o && inexact_o));

  assert_nan_invalid_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    unp.nan |-> (nxt_inv && !nxt_inx && nxt_res[INT_W-2:0] == '1));
endmodule

// File: tb/tb_f2i_conv.sv
module tb_f2i_conv;
  localparam int CLK_PERIOD = 10;
  localparam int W = 32;

  logic          clk = 1'b0;
  logic          rst_ni = 1'b0;
  logic [63:0]   operand;
  logic [1:0]    rnd, policy;
  logic [W-1:0]  result;
  logic          invalid, inexact;
  int            n_tests = 0;
  int            n_fail  = 0;
  bit            done    = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  f2i_conv #(.INT_W(W)) dut (
    .clk_i(clk), .rst_ni(rst_ni), .operand_i(operand), .rnd_i(rnd),
    .policy_i(policy), .result_o(result), .invalid_o(invalid), .inexact_o(inexact)
  );

  task automatic chk(input logic [63:0] op, input logic [1:0] rm, input logic [1:0] pl,
                     input logic [W-1:0] e_res, input logic e_inv, input logic e_inx,
                     input string tag);
    @(negedge clk);
    operand = op; rnd = rm; policy = pl;
    @(posedge clk); #1;
    n_tests++;
    if (result !== e_res || invalid !== e_inv || inexact !== e_inx) begin
      n_fail++;
      $display("FAIL %s op=%h rnd=%0d pol=%0d got res=%h inv=%b inx=%b exp res=%h inv=%b inx=%b",
               tag, op, rm, pl, result, invalid, inexact, e_res, e_inv, e_inx);
    end
  endtask

  // quarter-grid reference: q = value * 4
  task automatic ref_conv(input longint q, input int rm, input int pl,
                          output logic [W-1:0] r, output logic inv, output logic inx,
                          output string tag);
    longint fl, rem, rv;
    longint smax, smin, umax;
    smax = (longint'(1) << (W-1)) - 1;
    smin = -(longint'(1) << (W-1));
    umax = (longint'(1) << W) - 1;
    fl  = q >>> 2;
    rem = q - fl * 4;
    case (rm)
      0: rv = fl + (((rem > 2) || (rem == 2 && fl[0])) ? 1 : 0);
      1: rv = (q < 0 && rem != 0) ? fl + 1 : fl;
      2: rv = fl + ((rem != 0) ? 1 : 0);
      default: rv = fl;
    endcase
    inv = 1'b0;
    r = rv[W-1:0];
    if (pl == 0) begin
      if (rv > smax) begin r = smax[W-1:0]; inv = 1'b1; end
      else if (rv < smin) begin r = smin[W-1:0]; inv = 1'b1; end
    end else if (pl == 1) begin
      if (rv > umax) begin r = umax[W-1:0]; inv = 1'b1; end
      else if (rv < 0) begin r = '0; inv = 1'b1; end
    end else begin
      inv = (rv > smax) || (rv < smin);
    end
    inx = (rem != 0) && !inv;
    if ((pl == 0 && (rv == smax + 1 || rv == smin - 1)) || (pl == 1 && rv == umax + 1))
      tag = "R6";
    else if (inv && pl >= 2) tag = "R5";
    else if (inv && pl == 1) tag = "R4";
    else if (inv)            tag = "R3";
    else if (inx)            tag = "R7";
    else                     tag = "R2";
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog expired");
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

  initial begin
    longint cen [4];
    logic [W-1:0] e_r;
    logic e_i, e_x;
    string tg;
    cen[0] = 0;
    cen[1] = longint'(1) << 31;
    cen[2] = longint'(1) << 32;
    cen[3] = longint'(1) << 36;
    operand = 64'h3FF8000000000000; rnd = 2'b00; policy = 2'b00;
    repeat (3) @(posedge clk);
    #1;
    // R1: outputs cleared while reset held
    n_tests++;
    if (result !== '0 || invalid !== 1'b0 || inexact !== 1'b0) begin
      n_fail++;
      $display("FAIL R1 got res=%h inv=%b inx=%b exp res=0 inv=0 inx=0", result, invalid, inexact);
    end
    @(negedge clk) rst_ni = 1'b1;

    // sweep around each limit: R2 R3 R4 R5 R6 R7
    for (int c = 0; c < 4; c++)
      for (int o = -3; o <= 3; o++)
        for (int f = 0; f < 4; f++)
          for (int s = 0; s < 2; s++)
            for (int rm = 0; rm < 4; rm++)
              for (int pl = 0; pl < 3; pl++) begin
                longint q;
                real v;
                q = (cen[c] + o) * 4 + f;
                if (s == 1) q = -q;
                v = $itor(q) / 4.0;
                ref_conv(q, rm, pl, e_r, e_i, e_x, tg);
                chk($realtobits(v), 2'(rm), 2'(pl), e_r, e_i, e_x, tg);
              end

    // R8: NaN and infinity
    chk(64'h7FF8000000000001, 2'd0, 2'd0, 32'h7FFFFFFF, 1'b1, 1'b0, "R8");
    chk(64'hFFF8000000000000, 2'd1, 2'd1, 32'hFFFFFFFF, 1'b1, 1'b0, "R8");
    chk(64'h7FF0000000000010, 2'd2, 2'd2, 32'h7FFFFFFF, 1'b1, 1'b0, "R8");
    chk(64'h7FF0000000000000, 2'd0, 2'd1, 32'hFFFFFFFF, 1'b1, 1'b0, "R8");
    chk(64'hFFF0000000000000, 2'd0, 2'd1, 32'h00000000, 1'b1, 1'b0, "R8");
    chk(64'hFFF0000000000000, 2'd0, 2'd0, 32'h80000000, 1'b1, 1'b0, "R8");
    chk(64'hFFF0000000000000, 2'd0, 2'd2, 32'h80000000, 1'b1, 1'b0, "R8");
    // R5: magnitudes >= 2^65 under wrap, and clamping under the others (R3, R4)
    chk(64'h4450000000000000, 2'd0, 2'd2, 32'h00000000, 1'b1, 1'b0, "R5");
    chk(64'h4400000000000001, 2'd0, 2'd3, 32'h00002000, 1'b1, 1'b0, "R5");
    chk(64'hC400000000000001, 2'd0, 2'd2, 32'hFFFFE000, 1'b1, 1'b0, "R5");
    chk(64'h4450000000000000, 2'd0, 2'd0, 32'h7FFFFFFF, 1'b1, 1'b0, "R3");
    chk(64'hC450000000000000, 2'd0, 2'd1, 32'h00000000, 1'b1, 1'b0, "R4");
    // R9: zeros and subnormals
    chk(64'h8000000000000000, 2'd0, 2'd1, 32'h00000000, 1'b0, 1'b0, "R9");
    chk(64'h0000000000000001, 2'd0, 2'd0, 32'h00000000, 1'b0, 1'b1, "R9");
    chk(64'h0000000000000001, 2'd2, 2'd0, 32'h00000001, 1'b0, 1'b1, "R9");
    chk(64'h8000000000000001, 2'd3, 2'd0, 32'hFFFFFFFF, 1'b0, 1'b1, "R9");
    chk(64'h8000000000000001, 2'd3, 2'd1, 32'h00000000, 1'b1, 1'b0, "R9");
    chk(64'h8000000000000001, 2'd1, 2'd1, 32'h00000000, 1'b0, 1'b1, "R9");

    done = 1;
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule